// File: doc/BRIEF.md
# Key-Protected Power Domain Controller

This block sequences one switchable power domain, such as a processor core or an SRAM macro, through four power modes. Software selects a mode through a 32-bit register write. The block drives five control lines toward the domain: power enable, clock enable, isolation, reset hold and retention. It also reports a done flag that shows whether the requested mode has been reached. A write to the mode register is accepted only when its upper half-word carries an unlock key, which guards against stray writes. The upper half-word always reads back as the key with its two bytes swapped.

A second register holds the power-up delay. When the domain leaves an unpowered mode, the sequencer first switches power on and holds isolation for the programmed number of cycles. It then removes isolation, starts the clock, and finally releases reset (or retention) before it reports done. The retained mode is honoured only while the domain signals deep sleep. A retained request made at any other time stays pending. A parameter marks SRAM-type instances, for which code 1 is a reserved code and is refused.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: A mode-register write (`wr_sel`=0) changes the mode only when `wr_data[31:16]` equals 0x05FA. Any other key, including 0xFA05, leaves the mode and the outputs unchanged.
- R2: With `rd_sel`=0, `rd_data` is {16'hFA05, 14'b0, mode[1:0]}. With `rd_sel`=1, it is the delay register zero-extended from its 10 bits. Delay writes (`wr_sel`=1) take `wr_data[9:0]` and need no key.
- R3: After reset, the mode is ENABLED (code 3), `done` is 1, the delay is 0, and the outputs show the ENABLED combination.
- R4: Code 0 (OFF) drives {pwr,clk,iso,rst,ret} = 0,0,1,1,0. It is reached one clock edge after the accepted write, from any state.
- R5: Code 1 (RESET) drives {pwr,clk,iso,rst,ret} = 1,0,0,1,0. From OFF it is reached D+3 edges after the write, where D is the delay.
- R6: Code 2 (RETAINED) drives {pwr,clk,iso,rst,ret} = 0,0,1,0,1. It is entered only on an edge where `deep_sleep` is 1. Until then the previous outputs stay and `done` stays 0.
- R7: Code 3 (ENABLED) drives {pwr,clk,iso,rst,ret} = 1,1,0,0,0. From OFF or RETAINED, power rises with isolation held for D+1 cycles. Isolation then drops, the clock starts one cycle later, reset or retention releases one cycle after that, and `done` rises D+4 edges after the write.
- R8: In an SRAM-type instance (SRAM_TYPE=1), a keyed write of code 1 is ignored.
- R9: `done` is 1 exactly when the sequencer has reached the requested mode. It drops in the cycle after any accepted mode change to a different mode.
- R10: From RESET to ENABLED no delay is counted. The clock starts on the first edge, reset releases on the second, and `done` rises 2 edges after the write.
- R11: The clock is never enabled while power is off or isolation is on, and isolation is on whenever power is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 mode register, 1 delay register |
| wr_data | input | 32 | Write data; key in [31:16] for mode writes |
| rd_sel | input | 1 | Read target: 0 mode register, 1 delay register |
| rd_data | output | 32 | Read data of the selected register |
| deep_sleep | input | 1 | Domain reports deep sleep |
| pwr_en | output | 1 | Domain power switch enable |
| clk_en | output | 1 | Domain clock enable |
| iso_en | output | 1 | Domain output isolation |
| rst_hold | output | 1 | Domain reset asserted |
| ret_en | output | 1 | Domain state retention |
| done | output | 1 | Requested mode has been reached |

## Verification
The bench builds a general instance with SRAM_TYPE=0 and an SRAM-type instance with SRAM_TYPE=1, both with the default 10-bit delay. The delay sweep runs over 0 to 6 and the maximum of 1023. This keeps every power-up count within a few thousand cycles, and it brings both the zero-delay and the counter-saturating ends within reach. Each entry path into ENABLED, RESET and RETAINED is measured as an edge count against formulas in D.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_RST = 2'd1,
    MODE_RET = 2'd2,
    MODE_ON  = 2'd3
  } pmode_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_RST,
    ST_RET,
    ST_RAMP,
    ST_UNISO,
    ST_CLKON,
    ST_ON
  } seq_e;

  typedef struct packed {
    logic pwr;
    logic clk;
    logic iso;
    logic rst;
    logic ret;
  } dom_ctl_t;

  // Control combination for a sequencer step; hold selects whether reset
  // (1) or retention (0) protects the domain during power-up steps.
  function automatic dom_ctl_t ctl_of(seq_e s, logic hold);
    dom_ctl_t c;
    unique case (s)
      ST_OFF:   c = '{pwr: 1'b0, clk: 1'b0, iso: 1'b1, rst: 1'b1, ret: 1'b0};
      ST_RST:   c = '{pwr: 1'b1, clk: 1'b0, iso: 1'b0, rst: 1'b1, ret: 1'b0};
      ST_RET:   c = '{pwr: 1'b0, clk: 1'b0, iso: 1'b1, rst: 1'b0, ret: 1'b1};
      ST_RAMP:  c = '{pwr: 1'b1, clk: 1'b0, iso: 1'b1, rst: hold, ret: ~hold};
      ST_UNISO: c = '{pwr: 1'b1, clk: 1'b0, iso: 1'b0, rst: hold, ret: ~hold};
      ST_CLKON: c = '{pwr: 1'b1, clk: 1'b1, iso: 1'b0, rst: hold, ret: ~hold};
      default:  c = '{pwr: 1'b1, clk: 1'b1, iso: 1'b0, rst: 1'b0, ret: 1'b0};
    endcase
    return c;
  endfunction

  // Final sequencer step that corresponds to a requested mode.
  function automatic seq_e final_of(pmode_e m);
    seq_e s;
    unique case (m)
      MODE_OFF: s = ST_OFF;
      MODE_RST: s = ST_RST;
      MODE_RET: s = ST_RET;
      default:  s = ST_ON;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pdc_key_regs.sv
module pdc_key_regs
  import pdc_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          DLY_W      = 10,
  parameter logic [15:0] UNLOCK_KEY = 16'h05FA,
  parameter bit          SRAM_TYPE  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output pmode_e            mode,
  output logic [DLY_W-1:0]  dly
);

  localparam int          KEY_W    = DATA_W / 2;
  localparam int          PAD_W    = KEY_W - 2;
  localparam logic [15:0] READ_TAG = {UNLOCK_KEY[7:0], UNLOCK_KEY[15:8]};

  pmode_e           mode_q, mode_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             key_ok;
  logic             code_ok;

  assign key_ok  = (wr_data[DATA_W-1:KEY_W] == UNLOCK_KEY);
  assign code_ok = !(SRAM_TYPE && (wr_data[1:0] == 2'd1));

  always_comb begin
    mode_d = mode_q;
    dly_d  = dly_q;
    if (wr_en) begin
      if (wr_sel) begin
        dly_d = wr_data[DLY_W-1:0];
      end else if (key_ok && code_ok) begin
        mode_d = pmode_e'(wr_data[1:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ON;
      dly_q  <= '0;
    end else if (wr_en) begin
      mode_q <= mode_d;
      dly_q  <= dly_d;
    end
  end

  always_comb begin
    if (rd_sel) rd_data = {{(DATA_W-DLY_W){1'b0}}, dly_q};
    else        rd_data = {READ_TAG, {PAD_W{1'b0}}, mode_q};
  end

  assign mode = mode_q;
  assign dly  = dly_q;

endmodule

// File: rtl/pdc_seq.sv
module pdc_seq
  import pdc_pkg::*;
#(
  parameter int DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pmode_e           mode,
  input  logic [DLY_W-1:0] dly,
  input  logic             deep_sleep,
  output dom_ctl_t         ctl,
  output logic             done
);

  seq_e             st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             hold_q, hold_d;
  dom_ctl_t         ctl_q, ctl_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    hold_d = hold_q;

    // Remember how the domain was protected before power was raised.
    unique case (st_q)
      ST_OFF, ST_RST: hold_d = 1'b1;
      ST_RET:         hold_d = 1'b0;
      default:        ;
    endcase

    unique case (mode)
      MODE_OFF: st_d = ST_OFF;
      MODE_RET: begin
        if (deep_sleep) st_d = ST_RET;
      end
      MODE_RST: begin
        unique case (st_q)
          ST_OFF, ST_RET: begin
            st_d  = ST_RAMP;
            cnt_d = dly;
          end
          ST_RAMP: begin
            if (cnt_q == '0) st_d = ST_UNISO;
            else             cnt_d = cnt_q - 1'b1;
          end
          default: st_d = ST_RST;
        endcase
      end
      default: begin
        unique case (st_q)
          ST_OFF, ST_RET: begin
            st_d  = ST_RAMP;
            cnt_d = dly;
          end
          ST_RAMP: begin
            if (cnt_q == '0) st_d = ST_UNISO;
            else             cnt_d = cnt_q - 1'b1;
          end
          ST_UNISO, ST_RST: st_d = ST_CLKON;
          default:          st_d = ST_ON;
        endcase
      end
    endcase

    ctl_d = ctl_of(st_d, hold_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ON;
      cnt_q  <= '0;
      hold_q <= 1'b0;
      ctl_q  <= ctl_of(ST_ON, 1'b0);
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      ctl_q  <= ctl_d;
    end
  end

  assign ctl  = ctl_q;
  assign done = (st_q == final_of(mode));

endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl
  import pdc_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          DLY_W      = 10,
  parameter logic [15:0] UNLOCK_KEY = 16'h05FA,
  parameter bit          SRAM_TYPE  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              deep_sleep,
  output logic              pwr_en,
  output logic              clk_en,
  output logic              iso_en,
  output logic              rst_hold,
  output logic              ret_en,
  output logic              done
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  pmode_e           mode;
  logic [DLY_W-1:0] dly;
  dom_ctl_t         ctl;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  pdc_key_regs #(
    .DATA_W    (DATA_W),
    .DLY_W     (DLY_W),
    .UNLOCK_KEY(UNLOCK_KEY),
    .SRAM_TYPE (SRAM_TYPE)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .rd_sel (rd_sel),
    .rd_data(rd_data),
    .mode   (mode),
    .dly    (dly)
  );

  pdc_seq #(
    .DLY_W(DLY_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .mode      (mode),
    .dly       (dly),
    .deep_sleep(deep_sleep),
    .ctl       (ctl),
    .done      (done)
  );

  assign pwr_en   = ctl.pwr;
  assign clk_en   = ctl.clk;
  assign iso_en   = ctl.iso;
  assign rst_hold = ctl.rst;
  assign ret_en   = ctl.ret;

endmodule

// File: rtl/pwr_domain_ctrl_chk.sv
module pwr_domain_ctrl_chk #(
  parameter int          DATA_W     = 32,
  parameter logic [15:0] UNLOCK_KEY = 16'h05FA
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [1:0]        mode,
  input logic              deep_sleep,
  input logic              pwr_en,
  input logic              clk_en,
  input logic              iso_en,
  input logic              rst_hold,
  input logic              ret_en,
  input logic              done
);

  // R1
  key_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && !wr_sel && wr_data[DATA_W-1:DATA_W/2] != UNLOCK_KEY) |=> $stable(mode));

  // R11
  iso_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !pwr_en |-> iso_en);

  // R11
  clk_live_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    clk_en |-> (pwr_en && !iso_en));

  // R7
  iso_after_power_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(iso_en) |-> $past(pwr_en));

  // R6
  ret_deep_only_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(ret_en) |-> $past(deep_sleep));

  // R9
  done_on_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && mode == 2'd3) |-> (pwr_en && clk_en && !iso_en && !rst_hold && !ret_en));

  // R9
  done_off_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && mode == 2'd0) |-> (!pwr_en && !clk_en && iso_en && rst_hold && !ret_en));

endmodule

bind pwr_domain_ctrl pwr_domain_ctrl_chk #(
  .DATA_W    (DATA_W),
  .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .mode      (mode),
  .deep_sleep(deep_sleep),
  .pwr_en    (pwr_en),
  .clk_en    (clk_en),
  .iso_en    (iso_en),
  .rst_hold  (rst_hold),
  .ret_en    (ret_en),
  .done      (done)
);

// File: tb/pwr_domain_ctrl_tb.sv
module pwr_domain_ctrl_tb;

  localparam logic [4:0] C_OFF = 5'b00110;
  localparam logic [4:0] C_RST = 5'b10010;
  localparam logic [4:0] C_RET = 5'b00101;
  localparam logic [4:0] C_ON  = 5'b11000;
  localparam logic [15:0] KEY  = 16'h05FA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_en_s = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic        deep_sleep = 1'b0;
  logic [31:0] rd_data, rd_data_s;
  logic        pwr_en, clk_en, iso_en, rst_hold, ret_en, done;
  logic        pwr_s, clk_s, iso_s, rst_s, ret_s, done_s;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  pwr_domain_ctrl #(.SRAM_TYPE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .deep_sleep(deep_sleep),
    .pwr_en(pwr_en), .clk_en(clk_en), .iso_en(iso_en), .rst_hold(rst_hold),
    .ret_en(ret_en), .done(done)
  );

  pwr_domain_ctrl #(.SRAM_TYPE(1'b1)) u_dut_sram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_s), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data_s), .deep_sleep(deep_sleep),
    .pwr_en(pwr_s), .clk_en(clk_s), .iso_en(iso_s), .rst_hold(rst_s),
    .ret_en(ret_s), .done(done_s)
  );

  function automatic logic [4:0] combo();
    return {pwr_en, clk_en, iso_en, rst_hold, ret_en};
  endfunction

  function automatic logic [31:0] mode_word(logic [1:0] m);
    return {16'hFA05, 14'd0, m};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sram, input bit sel, input logic [31:0] d);
    @(negedge clk);
    wr_sel  = sel;
    wr_data = d;
    if (sram) wr_en_s = 1'b1; else wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b0;
    wr_en_s = 1'b0;
  endtask

  // Counts edges until done; also counts samples with power on and isolation on.
  task automatic wait_done(output int k, output int iso_cnt);
    k = 0;
    iso_cnt = 0;
    while (!done && k < 3000) begin
      @(posedge clk);
      @(negedge clk);
      k++;
      if (pwr_en && iso_en) iso_cnt++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int k, ic;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R3 reset state
    check(done == 1'b1, "R3 done", 32'(done), 32'd1);
    check(combo() == C_ON, "R3 outputs", 32'(combo()), 32'(C_ON));
    rd_sel = 1'b0; #1;
    check(rd_data == mode_word(2'd3), "R3 mode readback", rd_data, mode_word(2'd3));
    rd_sel = 1'b1; #1;
    check(rd_data == 32'd0, "R3 delay zero", rd_data, 32'd0);
    rd_sel = 1'b0;

    // R1 wrong keys, including the swapped key
    wr(1'b0, 1'b0, {16'h1234, 16'h0000});
    wr(1'b0, 1'b0, {16'hFA05, 16'h0000});
    wr(1'b0, 1'b0, {16'h05FB, 16'h0001});
    idle(3);
    #1;
    check(rd_data == mode_word(2'd3), "R1 wrong key mode", rd_data, mode_word(2'd3));
    check(combo() == C_ON && done, "R1 wrong key outputs", 32'(combo()), 32'(C_ON));

    // R4 OFF, one edge; R9 done drops immediately
    wr(1'b0, 1'b0, {KEY, 16'h0000});
    check(done == 1'b0, "R9 done low after change", 32'(done), 32'd0);
    wait_done(k, ic);
    check(k == 1, "R4 OFF latency", 32'(k), 32'd1);
    check(combo() == C_OFF, "R4 OFF outputs", 32'(combo()), 32'(C_OFF));
    #1;
    check(rd_data == mode_word(2'd0), "R2 readback after key write", rd_data, mode_word(2'd0));

    // R7 power-up sweep over the delay
    for (int d = 0; d <= 7; d++) begin
      automatic int dv = (d == 7) ? 1023 : d;
      wr(1'b0, 1'b1, {16'hABCD, 6'd0, 10'(dv)});
      rd_sel = 1'b1; #1;
      check(rd_data == 32'(dv), "R2 delay readback", rd_data, 32'(dv));
      rd_sel = 1'b0;
      wr(1'b0, 1'b0, {KEY, 16'h0003});
      wait_done(k, ic);
      check(k == dv + 4, "R7 ENABLED latency", 32'(k), 32'(dv + 4));
      check(ic == dv + 1, "R7 isolation hold", 32'(ic), 32'(dv + 1));
      check(combo() == C_ON, "R7 ENABLED outputs", 32'(combo()), 32'(C_ON));
      wr(1'b0, 1'b0, {KEY, 16'h0000});
      wait_done(k, ic);
    end

    // R5 OFF -> RESET with delay 3
    wr(1'b0, 1'b1, 32'd3);
    wr(1'b0, 1'b0, {KEY, 16'h0001});
    wait_done(k, ic);
    check(k == 6, "R5 RESET latency", 32'(k), 32'd6);
    check(combo() == C_RST, "R5 RESET outputs", 32'(combo()), 32'(C_RST));

    // R10 RESET -> ENABLED without delay
    wr(1'b0, 1'b0, {KEY, 16'h0003});
    @(posedge clk); @(negedge clk);
    check(combo() == 5'b11010, "R10 clock before release", 32'(combo()), 32'h1A);
    wait_done(k, ic);
    check(k == 1 && combo() == C_ON, "R10 ENABLED after 2 edges", 32'(k + 1), 32'd2);

    // R6 RETAINED pends without deep sleep
    deep_sleep = 1'b0;
    wr(1'b0, 1'b0, {KEY, 16'h0002});
    idle(5);
    check(done == 1'b0, "R6 pending done", 32'(done), 32'd0);
    check(combo() == C_ON, "R6 pending outputs", 32'(combo()), 32'(C_ON));
    deep_sleep = 1'b1;
    wait_done(k, ic);
    check(k == 1, "R6 RETAINED latency", 32'(k), 32'd1);
    check(combo() == C_RET, "R6 RETAINED outputs", 32'(combo()), 32'(C_RET));

    // R7 RETAINED -> ENABLED, delay 2, retention kept while ramping
    deep_sleep = 1'b0;
    wr(1'b0, 1'b1, 32'd2);
    wr(1'b0, 1'b0, {KEY, 16'h0003});
    @(posedge clk); @(negedge clk);
    check(combo() == 5'b10101, "R7 ramp keeps retention", 32'(combo()), 32'h15);
    wait_done(k, ic);
    check(k + 1 == 6, "R7 wake latency", 32'(k + 1), 32'd6);
    check(combo() == C_ON, "R7 wake outputs", 32'(combo()), 32'(C_ON));

    // R8 SRAM-type instance refuses code 1, accepts code 0
    wr(1'b1, 1'b0, {KEY, 16'h0001});
    idle(3);
    #1;
    check(rd_data_s == mode_word(2'd3), "R8 reserved code readback", rd_data_s, mode_word(2'd3));
    check({pwr_s, clk_s, iso_s, rst_s, ret_s} == C_ON && done_s, "R8 reserved code outputs",
          32'({pwr_s, clk_s, iso_s, rst_s, ret_s}), 32'(C_ON));
    wr(1'b1, 1'b0, {KEY, 16'h0000});
    idle(1);
    check({pwr_s, clk_s, iso_s, rst_s, ret_s} == C_OFF, "R8 SRAM OFF accepted",
          32'({pwr_s, clk_s, iso_s, rst_s, ret_s}), 32'(C_OFF));

    // R11 sanity in the final ENABLED state
    check(!clk_en || (pwr_en && !iso_en), "R11 clock gating", 32'(combo()), 32'(C_ON));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule